// File: doc/BRIEF.md
# Dithered Quadrature Numerically Controlled Oscillator

This block is a phase-accumulator oscillator that produces a matched pair of quantised sine and cosine samples on every clock. A wide frequency word arrives at the input and is cut down to a narrower phase increment. The increment is summed into a phase accumulator, and the top bits of the accumulator address a waveform table. The table is computed while the design elaborates, so no external content file is needed.

The block loses precision in two places: when the frequency word is narrowed to the increment width, and when the accumulator is narrowed to the table address. When dithering is enabled, a triangular-distribution random value is added at each of these two points just before the discarded bits are dropped. The dither is the sum of two uniform values drawn from two independent LFSRs, and it is one bit wider than the number of bits dropped. Spurious tones from truncation are spread into a white floor instead. When dithering is disabled, both points truncate plainly, and the outputs then follow a bit-exact reference accumulator.

The cosine comes from the same table as the sine, read a quarter cycle ahead. The two outputs therefore have identical amplitude. The increment register and the accumulator are also brought out in full, for use as frequency and phase readouts.

Top module: `nco_dither_quad`

## Requirements
- R1: While `rst_n` is low, `pir_out`, `acc_out`, `sin_out` and `cos_out` are all zero at the next clock edge and stay zero.
- R2: With `dither_en` low, `pir_out` one clock after an edge equals the top `PIR_W` bits of `freq_word` sampled at that edge (the low `FREQ_W-PIR_W` bits are discarded).
- R3: On every active clock, `acc_out` becomes the previous `acc_out` plus the previous `pir_out`, modulo 2^`PIR_W`.
- R4: With `dither_en` low, `sin_out` and `cos_out` one clock after an edge are the table entries at address `acc_out >> (PIR_W-ADDR_W)`, where `acc_out` is the value held before that edge.
- R5: The table entry at address a is within 1 LSB of round((2^(`AMP_W`-1)-1)·sin(2πa/2^`ADDR_W`)), and neither output ever takes the most negative code -2^(`AMP_W`-1).
- R6: The cosine output for address a equals exactly the sine table entry at address (a + 2^(`ADDR_W`-2)) mod 2^`ADDR_W`.
- R7: The table entry at address a + 2^(`ADDR_W`-1) is the exact two's-complement negation of the entry at address a.
- R8: With `dither_en` high, each `pir_out` lies within -1..+2 LSB (modulo 2^`PIR_W`) of the plain truncation of `freq_word`. Over a long run its mean matches `freq_word`/2^(`FREQ_W`-`PIR_W`) to within 1/8 LSB, and it does not stay constant.
- R9: With `dither_en` high, the table address used lies within -1..+2 of the plain address taken from the previous `acc_out`, and it does differ from the plain address on some cycles.
- R10: Lowering `dither_en` returns the block to the exact plain behaviour of R2 and R4 from the very next clock edge. The accumulator keeps running and is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_word | input | FREQ_W | Wide frequency word |
| dither_en | input | 1 | High: triangular dither at both truncation points; low: plain truncation |
| sin_out | output | AMP_W | Signed quantised sine sample |
| cos_out | output | AMP_W | Signed quantised cosine sample |
| pir_out | output | PIR_W | Phase increment register |
| acc_out | output | PIR_W | Phase accumulator |

## Verification
Stepping the accumulator by one increment per clock walks every table address. This sweep catches four kinds of table error:
- a mis-rounded entry or an entry that clips to the most negative code;
- a cosine offset that is off by one address, which breaks the quarter-cycle match;
- a half-wave built from a different rounding than its mirror, which breaks exact negation;
- an extra or missing pipeline register, which shows up as a one-cycle skew against the bench's own accumulator.

Wrap-around of the accumulator is forced by an all-ones frequency word. With dither on, a frequency word carrying a fractional remainder exposes three faults: dither that is missing, dither that is biased, or dither that is applied at only one of the two truncation points. Missing dither gives a constant increment, a mean stuck at the truncated value, or addresses that never move away from the plain ones. Biased or wrongly sized dither gives increments or addresses outside the allowed window. A final switch back to plain mode checks that no dither leaks through once it is disabled.

// File: rtl/nco_dq_pkg.sv
// Package: shared constants and the elaboration-time waveform function for
// the dithered quadrature oscillator.
// Assumes: address width of at least 3 and amplitude width of at most 24.
package nco_dq_pkg;

    localparam int          LFSR_W      = 32;
    localparam logic [31:0] LFSR_POLY_A = 32'hB4BC_D35C;
    localparam logic [31:0] LFSR_POLY_B = 32'hD000_0001;
    localparam logic [31:0] LFSR_SEED_A = 32'h1ACE_B00C;
    localparam logic [31:0] LFSR_SEED_B = 32'h5EED_0F0F;

    // pi/2 scaled by 2^30
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Rounded sine sample for table index idx, using only integer arithmetic.
    // A Taylor series is evaluated on the first quarter; the other quarters
    // are mirrored so that both symmetries hold exactly.
    function automatic int sine_sample(int idx, int addr_w, int amp_w);
        int     full;
        int     quarter;
        int     pos;
        int     p;
        bit     neg;
        longint x;
        longint x2;
        longint term;
        longint acc;
        longint amp;
        longint v;
        full    = 1 << addr_w;
        quarter = full >> 2;
        pos     = idx & (full - 1);
        neg     = (pos >= 2 * quarter);
        p       = pos % (2 * quarter);
        if (p > quarter) p = 2 * quarter - p;
        x    = (longint'(p) * HALF_PI_Q30) >>> (addr_w - 2);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        amp = (64'sd1 <<< (amp_w - 1)) - 64'sd1;
        v   = (acc * amp + (64'sd1 <<< 29)) >>> 30;
        if (v > amp) v = amp;
        if (v < 0)   v = 0;
        return neg ? -int'(v) : int'(v);
    endfunction

endpackage

// File: rtl/nco_lfsr.sv
// Module: right-shifting Galois LFSR that is used as a uniform random source.
// Assumes: POLY has its top bit set and SEED is non-zero, so the state never
// reaches zero.
module nco_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = '1,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    // Advance the register by one step on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (state[0]) begin
            state <= (state >> 1) ^ POLY;
        end else begin
            state <= state >> 1;
        end
    end

endmodule

// File: rtl/nco_dither_trunc.sv
// Module: combinational truncation from IN_W to OUT_W bits, with an optional
// triangular dither of (IN_W-OUT_W+1) bits added first.
// The dither is ua+ub, each uniform over DROP bits, shifted down by
// 2^(DROP-1)-1. This centres it on half an output LSB, so the floor acts as
// rounding. When en is low the value is truncated plainly.
// Assumes: IN_W > OUT_W; ua and ub are independent.
module nco_dither_trunc #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]       value,
    input  logic [IN_W-OUT_W-1:0] ua,
    input  logic [IN_W-OUT_W-1:0] ub,
    input  logic                  en,
    output logic [OUT_W-1:0]      result
);

    localparam int DROP   = IN_W - OUT_W;
    localparam int OFFSET = (1 << (DROP - 1)) - 1;

    logic [DROP:0]     tri_d;
    logic [IN_W-1:0]   shifted;

    // Form the triangular dither as the sum of two uniform values.
    always_comb begin
        tri_d = en ? ({1'b0, ua} + {1'b0, ub}) : '0;
    end

    // Add the centred dither and keep the upper OUT_W bits.
    always_comb begin
        shifted = value + IN_W'(tri_d) - (en ? IN_W'(OFFSET) : '0);
        result  = OUT_W'(shifted >> DROP);
    end

endmodule

// File: rtl/nco_quad_rom.sv
// Module: full-cycle waveform table with a registered quadrature read.
// The sine is read at addr and the cosine at addr plus a quarter cycle, both
// from the same table. Latency is one clock.
// Assumes: the table holds 2^ADDR_W entries and is built at elaboration.
module nco_quad_rom #(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [AMP_W-1:0]  sin_q,
    output logic signed [AMP_W-1:0]  cos_q
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int QUARTER = DEPTH >> 2;

    logic signed [AMP_W-1:0] wave [DEPTH];
    logic [ADDR_W-1:0]       cos_addr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_wave
        assign wave[i] = AMP_W'(nco_dq_pkg::sine_sample(i, ADDR_W, AMP_W));
    end

    // Cosine address: a quarter cycle ahead, wrapping at the table size.
    always_comb begin
        cos_addr = addr + ADDR_W'(QUARTER);
    end

    // Registered read of both quadrature samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= wave[addr];
            cos_q <= wave[cos_addr];
        end
    end

endmodule

// File: rtl/nco_dither_quad.sv
// Module: top of the dithered quadrature oscillator.
// Pipeline:
//   freq_word -> dithered truncation -> pir_q
//   acc_q     += pir_q
//   acc_q     -> dithered truncation -> table address -> registered sin/cos
// Assumes: FREQ_W > PIR_W > ADDR_W >= 3,
//          (FREQ_W-PIR_W)+(PIR_W-ADDR_W) < 32,
//          synchronous active-low reset.
module nco_dither_quad #(
    parameter int FREQ_W = 16,
    parameter int PIR_W  = 12,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FREQ_W-1:0]       freq_word,
    input  logic                    dither_en,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out,
    output logic [PIR_W-1:0]        pir_out,
    output logic [PIR_W-1:0]        acc_out
);

    localparam int DROP_F = FREQ_W - PIR_W;
    localparam int DROP_P = PIR_W - ADDR_W;
    localparam int SPLIT  = DROP_F + DROP_P;

    logic [nco_dq_pkg::LFSR_W-1:0] rnd_a;
    logic [nco_dq_pkg::LFSR_W-1:0] rnd_b;
    logic [PIR_W-1:0]              pir_next;
    logic [PIR_W-1:0]              pir_q;
    logic [PIR_W-1:0]              acc_q;
    logic [ADDR_W-1:0]             lut_addr;
    logic                          unused_rnd_bits;

    nco_lfsr #(
        .W    (nco_dq_pkg::LFSR_W),
        .POLY (nco_dq_pkg::LFSR_POLY_A),
        .SEED (nco_dq_pkg::LFSR_SEED_A)
    ) u_rnd_a (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd_a)
    );

    nco_lfsr #(
        .W    (nco_dq_pkg::LFSR_W),
        .POLY (nco_dq_pkg::LFSR_POLY_B),
        .SEED (nco_dq_pkg::LFSR_SEED_B)
    ) u_rnd_b (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd_b)
    );

    // Only the low SPLIT bits of each LFSR feed the dither.
    assign unused_rnd_bits = ^{rnd_a[nco_dq_pkg::LFSR_W-1:SPLIT],
                               rnd_b[nco_dq_pkg::LFSR_W-1:SPLIT]};

    nco_dither_trunc #(
        .IN_W  (FREQ_W),
        .OUT_W (PIR_W)
    ) u_freq_trunc (
        .value  (freq_word),
        .ua     (rnd_a[DROP_F-1:0]),
        .ub     (rnd_b[DROP_F-1:0]),
        .en     (dither_en),
        .result (pir_next)
    );

    nco_dither_trunc #(
        .IN_W  (PIR_W),
        .OUT_W (ADDR_W)
    ) u_phase_trunc (
        .value  (acc_q),
        .ua     (rnd_a[SPLIT-1:DROP_F]),
        .ub     (rnd_b[SPLIT-1:DROP_F]),
        .en     (dither_en),
        .result (lut_addr)
    );

    // Register the increment and advance the phase accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pir_q <= '0;
            acc_q <= '0;
        end else begin
            pir_q <= pir_next;
            acc_q <= acc_q + pir_q;
        end
    end

    nco_quad_rom #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (lut_addr),
        .sin_q (sin_out),
        .cos_q (cos_out)
    );

    assign pir_out = pir_q;
    assign acc_out = acc_q;

endmodule

// File: rtl/nco_dither_quad_chk.sv
// Module: property checker for nco_dither_quad, bound to every instance.
// Assumes: the same parameters as the bound instance.
module nco_dither_quad_chk #(
    parameter int FREQ_W = 16,
    parameter int PIR_W  = 12,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FREQ_W-1:0]       freq_word,
    input  logic                    dither_en,
    input  logic signed [AMP_W-1:0] sin_out,
    input  logic signed [AMP_W-1:0] cos_out,
    input  logic [PIR_W-1:0]        pir_out,
    input  logic [PIR_W-1:0]        acc_out
);

    localparam int                      DROP_F   = FREQ_W - PIR_W;
    localparam logic [PIR_W-1:0]        ALL_ONES = '1;
    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    // Plain mode: the increment is the upper part of the frequency word.
    assert_plain_pir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dither_en |=> pir_out == $past(PIR_W'(freq_word >> DROP_F)));

    // The accumulator adds the previous increment, modulo its width.
    assert_acc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> acc_out == PIR_W'($past(acc_out) + $past(pir_out)));

    // Samples never reach the most negative code.
    assert_no_most_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_out != MOST_NEG) && (cos_out != MOST_NEG));

    // Dithered increment stays within -1..+2 LSB of plain truncation.
    assert_pir_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dither_en |=>
            (PIR_W'(pir_out - $past(PIR_W'(freq_word >> DROP_F))) <= PIR_W'(2)) ||
            (PIR_W'(pir_out - $past(PIR_W'(freq_word >> DROP_F))) == ALL_ONES));

endmodule

bind nco_dither_quad nco_dither_quad_chk #(
    .FREQ_W (FREQ_W),
    .PIR_W  (PIR_W),
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .dither_en (dither_en),
    .sin_out   (sin_out),
    .cos_out   (cos_out),
    .pir_out   (pir_out),
    .acc_out   (acc_out)
);

// File: tb/tb_nco_dither_quad.sv
// Bench: full sweep of every table address, plain-mode exact tracking against
// a bench accumulator, and statistical checks of the dithered mode.
module tb_nco_dither_quad;

    localparam int CLK_P  = 10;
    localparam int FW     = 16;
    localparam int TW     = 12;
    localparam int LW     = 8;
    localparam int MW     = 10;
    localparam int D1     = FW - TW;
    localparam int D2     = TW - LW;
    localparam int PMOD   = 1 << TW;
    localparam int NADDR  = 1 << LW;
    localparam int QTR    = NADDR / 4;
    localparam int HALF   = NADDR / 2;
    localparam int AMP    = (1 << (MW - 1)) - 1;
    localparam int NDITH  = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [FW-1:0]        freq_word = '0;
    logic                 dither_en = 1'b0;
    logic signed [MW-1:0] sin_out;
    logic signed [MW-1:0] cos_out;
    logic [TW-1:0]        pir_out;
    logic [TW-1:0]        acc_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_pir = 0;
    int m_acc = 0;
    int m_addr = 0;
    int sin_tab [NADDR];
    int cos_tab [NADDR];

    always #(CLK_P/2) clk = ~clk;

    nco_dither_quad #(
        .FREQ_W (FW),
        .PIR_W  (TW),
        .ADDR_W (LW),
        .AMP_W  (MW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .dither_en (dither_en),
        .sin_out   (sin_out),
        .cos_out   (cos_out),
        .pir_out   (pir_out),
        .acc_out   (acc_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sin_obs();
        return int'($signed(sin_out));
    endfunction

    function automatic int cos_obs();
        return int'($signed(cos_out));
    endfunction

    // Bench model of one active clock edge in plain mode.
    task automatic tick();
        @(posedge clk);
        m_addr = m_acc >> D2;
        m_acc  = (m_acc + m_pir) % PMOD;
        m_pir  = int'(freq_word) >> D1;
        @(negedge clk);
    endtask

    function automatic int ideal_sine(int a);
        real r;
        r = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(a) / real'(NADDR));
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int fw_list [5];
        fw_list = '{32'h0000_FFFF, 32'h0000_8001, 32'h0000_1237,
                    32'h0000_0F0F, 32'h0000_0000};

        // R1: reset values
        repeat (3) @(negedge clk);
        chk(pir_out == '0, "R1 pir", int'(pir_out), 0);
        chk(acc_out == '0, "R1 acc", int'(acc_out), 0);
        chk(sin_out == '0, "R1 sin", sin_obs(), 0);
        chk(cos_out == '0, "R1 cos", cos_obs(), 0);

        // Sweep every address with unit increment (dither off).
        freq_word = FW'(1 << D1);
        rst_n = 1'b1;
        for (int i = 0; i < PMOD + 4; i++) begin
            tick();
            chk(int'(pir_out) == m_pir, "R2 pir plain", int'(pir_out), m_pir);
            chk(int'(acc_out) == m_acc, "R3 acc step", int'(acc_out), m_acc);
            sin_tab[m_addr] = sin_obs();
            cos_tab[m_addr] = cos_obs();
        end

        for (int a = 0; a < NADDR; a++) begin
            int e;
            int d;
            e = ideal_sine(a);
            d = sin_tab[a] - e;
            chk(d >= -1 && d <= 1, "R5 table accuracy", sin_tab[a], e);
            chk(sin_tab[a] != -(AMP + 1), "R5 most negative", sin_tab[a], -AMP);
            chk(cos_tab[a] == sin_tab[(a + QTR) % NADDR], "R6 quarter offset",
                cos_tab[a], sin_tab[(a + QTR) % NADDR]);
            chk(sin_tab[(a + HALF) % NADDR] == -sin_tab[a], "R7 half-wave",
                sin_tab[(a + HALF) % NADDR], -sin_tab[a]);
        end

        // Plain mode under several frequency words, including wrap-around.
        foreach (fw_list[j]) begin
            freq_word = FW'(fw_list[j]);
            for (int i = 0; i < 40; i++) begin
                tick();
                chk(int'(pir_out) == m_pir, "R2 pir plain", int'(pir_out), m_pir);
                chk(int'(acc_out) == m_acc, "R3 acc wrap", int'(acc_out), m_acc);
                chk(sin_obs() == sin_tab[m_addr], "R4 sin latency", sin_obs(), sin_tab[m_addr]);
                chk(cos_obs() == cos_tab[m_addr], "R4 cos latency", cos_obs(), cos_tab[m_addr]);
            end
        end

        // Dithered mode.
        begin
            int q;
            int prev_acc;
            int prev_pir;
            int sum;
            int moved;
            int varied;
            int dev;
            q = 32'h1237 >> D1;
            sum = 0;
            moved = 0;
            varied = 0;
            freq_word = FW'(32'h1237);
            dither_en = 1'b1;
            prev_acc = int'(acc_out);
            prev_pir = int'(pir_out);
            for (int i = 0; i < NDITH; i++) begin
                int p;
                int d;
                int base;
                bit hit;
                tick();
                p = int'(pir_out);
                d = (p - q + PMOD) % PMOD;
                chk(d <= 2 || d == PMOD - 1, "R8 pir window", p, q);
                chk(int'(acc_out) == (prev_acc + prev_pir) % PMOD, "R3 acc dithered",
                    int'(acc_out), (prev_acc + prev_pir) % PMOD);
                base = prev_acc >> D2;
                hit = 0;
                for (int o = -1; o <= 2; o++) begin
                    if (sin_obs() == sin_tab[(base + o + NADDR) % NADDR]) hit = 1;
                end
                chk(hit, "R9 address window", sin_obs(), sin_tab[base]);
                if (sin_obs() != sin_tab[base]) moved++;
                if (p != q) varied++;
                sum += p;
                prev_acc = int'(acc_out);
                prev_pir = p;
            end
            dev = sum * (1 << D1) - NDITH * 32'h1237;
            if (dev < 0) dev = -dev;
            chk(dev <= NDITH * (1 << D1) / 8, "R8 dithered mean", sum, NDITH * q);
            chk(varied > 0, "R8 increment varies", varied, 1);
            chk(moved > 0, "R9 address moves", moved, 1);
        end

        // Return to plain mode without reset.
        dither_en = 1'b0;
        freq_word = FW'(32'h0F0F);
        m_acc = int'(acc_out);
        m_pir = int'(pir_out);
        for (int i = 0; i < 40; i++) begin
            tick();
            chk(int'(pir_out) == m_pir, "R10 pir plain again", int'(pir_out), m_pir);
            chk(int'(acc_out) == m_acc, "R10 acc continues", int'(acc_out), m_acc);
            chk(sin_obs() == sin_tab[m_addr], "R10 sin plain again", sin_obs(), sin_tab[m_addr]);
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(pir_out == '0, "R1 pir mid reset", int'(pir_out), 0);
        chk(acc_out == '0, "R1 acc mid reset", int'(acc_out), 0);
        chk(sin_out == '0, "R1 sin mid reset", sin_obs(), 0);
        chk(cos_out == '0, "R1 cos mid reset", cos_obs(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule